// File: doc/BRIEF.md
# STM-1 Frame Aligner with Section Parity Check

This block sits behind line descrambling on the receive side of a 155.52 Mbit/s synchronous optical link. It accepts one byte per accepted cycle, qualified by a valid strobe. It looks for the six-byte framing word, three bytes of 0xF6 followed by three bytes of 0x28. It confirms the word at the expected spacing and then holds frame lock. Every accepted byte leaves the block one cycle later. It carries its row and column inside the 9 by 270 byte frame, and the first byte of each frame is flagged.

While locked, the block folds every byte of each full frame into an even 8-bit bit-interleaved parity. It compares that parity with the section parity byte, which sits in the second row, first column of the following frame. It reports the number of disagreeing bit lanes once per frame. Downstream logic uses the row and column to pick out overhead bytes. It uses the lock flag to gate alarms, and the error weight to feed section performance counters.

Top module: `sdh_frame_aligner`

## Requirements
- R1: After reset, `in_frame_o`, `vld_o`, `sof_o` and `b1_vld_o` are all 0.
- R2: While hunting, a framing word (0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28 on consecutive accepted bytes) starts a lock attempt. A second framing word that ends exactly 2430 accepted bytes after the first one raises `in_frame_o`. It rises in the same cycle that the last 0x28 byte appears at the output.
- R3: During a lock attempt, if the framing word is missing at the expected position, the block goes back to hunting and `in_frame_o` stays 0.
- R4: The byte that completes a framing word is reported at row 0, column 5. The following bytes advance the column modulo 270, and the row goes up by one (modulo 9) on each column wrap. `sof_o` is 1 exactly on the byte at row 0, column 0.
- R5: A cycle with `vld_i` low is ignored. `vld_o`, `sof_o` and `b1_vld_o` are 0 one cycle later, and the position count does not advance.
- R6: While locked, a missing framing word at the expected position counts as a miss. The fourth consecutive miss drops `in_frame_o` on that byte. A correct word clears the miss count.
- R7: While locked, a framing word at any other position does not change the row or column sequence.
- R8: While locked, `b1_vld_o` pulses for one output cycle on the byte at row 1, column 0. `b1_err_o` is then the number of 1 bits in the received byte XOR the even parity of all 2430 bytes of the previous frame.
- R9: No parity result is given while out of frame. None is given in the frame where lock is declared, nor in the frame after it. The first one comes in the second frame after the lock frame.
- R10: Each accepted byte appears on `data_o` with `vld_o` high exactly one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Descrambled line byte |
| data_o | output | 8 | Byte passed through, one cycle later |
| vld_o | output | 1 | Output byte valid |
| row_o | output | 4 | Row of the output byte (0 to 8) |
| col_o | output | 9 | Column of the output byte (0 to 269) |
| sof_o | output | 1 | Output byte is the first of a frame |
| in_frame_o | output | 1 | Frame lock held (low means out of frame) |
| b1_err_o | output | 4 | Count of mismatched parity lanes (0 to 8) |
| b1_vld_o | output | 1 | `b1_err_o` is valid this cycle |

## Verification
The checker tests these properties on every cycle:
- positions stay in range;
- the start-of-frame flag and the parity strobe fall only in their fixed slots;
- nothing is flagged on idle cycles;
- lock is gained and lost only on the framing-word slot;
- the row and column step by one between consecutive locked bytes.

The bench shows what only a full stream can: the exact spacing that confirms lock and the failed-confirmation path. It also covers the four-miss loss count, reset of the miss count by one good frame, and the two-frame suppression of parity after each lock. The error weights come from parity the bench builds itself, with chosen error masks, across gaps and a decoy framing word.

// File: rtl/sdh_fa_pkg.sv
`timescale 1ns/1ps
package sdh_fa_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } fa_state_e;

    // number of set bits in a parity difference
    function automatic logic [3:0] lane_weight(input logic [7:0] v);
        logic [3:0] w;
        w = 4'd0;
        for (int i = 0; i < 8; i++) begin
            w = w + {3'd0, v[i]};
        end
        return w;
    endfunction

endpackage

// File: rtl/sdh_fa_pattern.sv
`timescale 1ns/1ps
module sdh_fa_pattern #(
    parameter int          N_A = 3,
    parameter logic [7:0]  A1  = 8'hF6,
    parameter logic [7:0]  A2  = 8'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vld_i,
    input  logic [7:0] byte_i,
    output logic       match_o
);
    localparam int LEN  = 2 * N_A;
    localparam int HIST = LEN - 1;

    logic [7:0] hist_q [HIST];
    logic [7:0] hist_d [HIST];

    always_comb begin
        for (int k = 0; k < HIST; k++) begin
            hist_d[k] = hist_q[k];
        end
        if (vld_i) begin
            hist_d[0] = byte_i;
            for (int k = 1; k < HIST; k++) begin
                hist_d[k] = hist_q[k-1];
            end
        end
    end

    // hist_q[k] is the byte accepted k+1 valid cycles ago
    always_comb begin
        match_o = vld_i && (byte_i == A2);
        for (int k = 0; k < HIST; k++) begin
            if ((LEN - 2 - k) < N_A) begin
                if (hist_q[k] != A1) match_o = 1'b0;
            end else begin
                if (hist_q[k] != A2) match_o = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST; k++) hist_q[k] <= 8'h00;
        end else begin
            for (int k = 0; k < HIST; k++) hist_q[k] <= hist_d[k];
        end
    end
endmodule

// File: rtl/sdh_fa_bip.sv
`timescale 1ns/1ps
module sdh_fa_bip (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vld_i,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic [7:0] parity_o
);
    typedef struct packed {
        logic [7:0] acc;
        logic [7:0] prev;
    } bip_regs_t;

    bip_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (vld_i) begin
            if (start_i) begin
                r_d.prev = r_q.acc;
                r_d.acc  = byte_i;
            end else begin
                r_d.acc  = r_q.acc ^ byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign parity_o = r_q.prev;
endmodule

// File: rtl/sdh_frame_aligner.sv
`timescale 1ns/1ps
module sdh_frame_aligner #(
    parameter int         ROWS        = 9,
    parameter int         COLS        = 270,
    parameter int         N_A         = 3,
    parameter logic [7:0] A1          = 8'hF6,
    parameter logic [7:0] A2          = 8'h28,
    parameter int         LOCK_HITS   = 2,
    parameter int         LOSS_MISSES = 4,
    parameter int         B1_ROW      = 1,
    parameter int         B1_COL      = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [7:0]               byte_i,
    output logic [7:0]               data_o,
    output logic                     vld_o,
    output logic [$clog2(ROWS)-1:0]  row_o,
    output logic [$clog2(COLS)-1:0]  col_o,
    output logic                     sof_o,
    output logic                     in_frame_o,
    output logic [3:0]               b1_err_o,
    output logic                     b1_vld_o
);
    import sdh_fa_pkg::*;

    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = $clog2(COLS);
    localparam int CNT_MAX = (LOCK_HITS > LOSS_MISSES) ? LOCK_HITS : LOSS_MISSES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [COL_W-1:0] MARK_COL = COL_W'(2 * N_A - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [ROW_W-1:0] PAR_ROW  = ROW_W'(B1_ROW);
    localparam logic [COL_W-1:0] PAR_COL  = COL_W'(B1_COL);
    localparam logic [CNT_W-1:0] HIT_LIM  = CNT_W'(LOCK_HITS);
    localparam logic [CNT_W-1:0] MISS_LIM = CNT_W'(LOSS_MISSES);

    typedef struct packed {
        fa_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             full;
        logic             ok;
        logic [7:0]       data;
        logic             vld;
        logic [ROW_W-1:0] orow;
        logic [COL_W-1:0] ocol;
        logic             sof;
        logic [3:0]       err;
        logic             err_vld;
    } fa_regs_t;

    fa_regs_t r_q, r_d;

    logic             match;
    logic [7:0]       prev_parity;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             at_mark;
    logic             at_start;
    logic [CNT_W-1:0] cnt_inc;

    sdh_fa_pattern #(.N_A(N_A), .A1(A1), .A2(A2)) i_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_i),
        .byte_i  (byte_i),
        .match_o (match)
    );

    sdh_fa_bip i_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (vld_i),
        .start_i  (at_start),
        .byte_i   (byte_i),
        .parity_o (prev_parity)
    );

    // position of the byte at the input, realigned when hunting finds a word
    always_comb begin
        if (r_q.st == ST_HUNT && match) begin
            cur_row = '0;
            cur_col = MARK_COL;
        end else begin
            cur_row = r_q.row;
            cur_col = r_q.col;
        end
        at_mark  = (cur_row == '0) && (cur_col == MARK_COL);
        at_start = (cur_row == '0) && (cur_col == '0);
        cnt_inc  = r_q.cnt + 1'b1;
    end

    always_comb begin
        r_d         = r_q;
        r_d.vld     = vld_i;
        r_d.sof     = 1'b0;
        r_d.err_vld = 1'b0;
        if (vld_i) begin
            r_d.data = byte_i;
            r_d.orow = cur_row;
            r_d.ocol = cur_col;
            r_d.sof  = at_start;
            if (cur_col == LAST_COL) begin
                r_d.col = '0;
                r_d.row = (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
            end else begin
                r_d.col = cur_col + 1'b1;
                r_d.row = cur_row;
            end

            unique case (r_q.st)
                ST_HUNT: begin
                    if (match) begin
                        r_d.st  = ST_PRESYNC;
                        r_d.cnt = CNT_W'(1);
                    end
                end
                ST_PRESYNC: begin
                    if (at_mark) begin
                        if (!match) begin
                            r_d.st = ST_HUNT;
                        end else if (cnt_inc >= HIT_LIM) begin
                            r_d.st  = ST_SYNC;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_SYNC: begin
                    if (at_mark) begin
                        if (match) begin
                            r_d.cnt = '0;
                        end else if (cnt_inc >= MISS_LIM) begin
                            r_d.st = ST_HUNT;
                        end else begin
                            r_d.cnt = cnt_inc;
                        end
                    end
                end
                default: r_d.st = ST_HUNT;
            endcase

            // arm the parity compare only for frames that ran fully in lock
            if (at_start) begin
                r_d.ok   = r_q.full && (r_q.st == ST_SYNC);
                r_d.full = (r_q.st == ST_SYNC);
            end
            if (r_q.st == ST_SYNC && r_q.ok && cur_row == PAR_ROW && cur_col == PAR_COL) begin
                r_d.err_vld = 1'b1;
                r_d.err     = lane_weight(prev_parity ^ byte_i);
            end
            if (r_d.st != ST_SYNC) begin
                r_d.full = 1'b0;
                r_d.ok   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q    <= r_d;
        end
    end

    assign data_o     = r_q.data;
    assign vld_o      = r_q.vld;
    assign row_o      = r_q.orow;
    assign col_o      = r_q.ocol;
    assign sof_o      = r_q.sof;
    assign in_frame_o = (r_q.st == ST_SYNC);
    assign b1_err_o   = r_q.err;
    assign b1_vld_o   = r_q.err_vld;
endmodule

// File: rtl/sdh_frame_aligner_chk.sv
`timescale 1ns/1ps
module sdh_frame_aligner_chk #(
    parameter int ROWS   = 9,
    parameter int COLS   = 270,
    parameter int N_A    = 3,
    parameter int B1_ROW = 1,
    parameter int B1_COL = 0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vld_o,
    input logic [$clog2(ROWS)-1:0]  row_o,
    input logic [$clog2(COLS)-1:0]  col_o,
    input logic                     sof_o,
    input logic                     in_frame_o,
    input logic [3:0]               b1_err_o,
    input logic                     b1_vld_o
);
    localparam int MARK = 2 * N_A - 1;

    logic                     seen_q;
    logic [$clog2(ROWS)-1:0]  lrow_q;
    logic [$clog2(COLS)-1:0]  lcol_q;
    int                       nrow;
    int                       ncol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            lrow_q <= '0;
            lcol_q <= '0;
        end else if (!in_frame_o) begin
            seen_q <= 1'b0;
        end else if (vld_o) begin
            seen_q <= 1'b1;
            lrow_q <= row_o;
            lcol_q <= col_o;
        end
    end

    always_comb begin
        if (int'(lcol_q) == COLS - 1) begin
            ncol = 0;
            nrow = (int'(lrow_q) == ROWS - 1) ? 0 : int'(lrow_q) + 1;
        end else begin
            ncol = int'(lcol_q) + 1;
            nrow = int'(lrow_q);
        end
    end

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (int'(row_o) < ROWS) && (int'(col_o) < COLS));

    p_sof_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> vld_o && row_o == '0 && col_o == '0);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> !sof_o && !b1_vld_o);

    p_parity_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b1_vld_o |-> vld_o && in_frame_o && int'(row_o) == B1_ROW
                     && int'(col_o) == B1_COL && b1_err_o <= 4'd8);

    p_lock_on_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_o) |-> vld_o && row_o == '0 && int'(col_o) == MARK);

    p_loss_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame_o) |-> vld_o && row_o == '0 && int'(col_o) == MARK);

    p_locked_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && in_frame_o && seen_q) |-> int'(row_o) == nrow && int'(col_o) == ncol);
endmodule

bind sdh_frame_aligner sdh_frame_aligner_chk #(
    .ROWS(ROWS), .COLS(COLS), .N_A(N_A), .B1_ROW(B1_ROW), .B1_COL(B1_COL)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_o      (vld_o),
    .row_o      (row_o),
    .col_o      (col_o),
    .sof_o      (sof_o),
    .in_frame_o (in_frame_o),
    .b1_err_o   (b1_err_o),
    .b1_vld_o   (b1_vld_o)
);

// File: tb/test_sdh_frame_aligner.sv
`timescale 1ns/1ps
module test_sdh_frame_aligner;
    localparam int ROWS = 9;
    localparam int COLS = 270;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [7:0] data_o;
    logic       vld_o;
    logic [3:0] row_o;
    logic [8:0] col_o;
    logic       sof_o;
    logic       in_frame_o;
    logic [3:0] b1_err_o;
    logic       b1_vld_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] prev_par = 8'h00;

    always #10 clk = ~clk;

    sdh_frame_aligner i_sdh_frame_aligner (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .byte_i(byte_i),
        .data_o(data_o), .vld_o(vld_o), .row_o(row_o), .col_o(col_o),
        .sof_o(sof_o), .in_frame_o(in_frame_o), .b1_err_o(b1_err_o),
        .b1_vld_o(b1_vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    task automatic idle();
        @(negedge clk);
        vld_i  = 1'b0;
        byte_i = 8'hC3;
        @(posedge clk); #1;
        chk(vld_o == 1'b0, "R5 vld", vld_o, 0);
        chk(sof_o == 1'b0 && b1_vld_o == 1'b0, "R5 flags", {sof_o, b1_vld_o}, 0);
    endtask

    task automatic send(input logic [7:0] b, input bit trk, input int r, input int c,
                        input bit exp_if, input string if_tag, input string pos_tag,
                        input bit exp_b1, input int exp_err);
        @(negedge clk);
        vld_i  = 1'b1;
        byte_i = b;
        @(posedge clk); #1;
        chk(vld_o == 1'b1 && data_o == b, "R10", {vld_o, data_o}, {1'b1, b});
        if (trk) begin
            chk(int'(row_o) == r && int'(col_o) == c, pos_tag, int'(row_o) * 1000 + int'(col_o), r * 1000 + c);
            chk(sof_o == (r == 0 && c == 0), "R4 sof", sof_o, (r == 0 && c == 0));
        end
        chk(in_frame_o == exp_if, if_tag, in_frame_o, exp_if);
        chk(b1_vld_o == exp_b1, "R9 strobe", b1_vld_o, exp_b1);
        if (exp_b1) chk(int'(b1_err_o) == exp_err, "R8 weight", b1_err_o, exp_err);
    endtask

    // mode: 0 no position check, 1 from the framing mark on, 2 whole frame
    task automatic send_frame(input int f, input bit corrupt, input int mode,
                              input bit pre_if, input bit post_if, input bit b1_on,
                              input logic [7:0] mask, input string if_tag, input bit decoy);
        logic [7:0] par = 8'h00;
        logic [7:0] b;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (r == 0 && c < 3)       b = 8'hF6;
                else if (r == 0 && c < 6)  b = 8'h28;
                else if (r == 1 && c == 0) b = prev_par ^ mask;
                else                       b = 8'((f * 29 + r * 53 + c * 7 + 60) & 255);
                if (corrupt && r == 0 && c == 3) b = 8'h00;
                if (decoy && r == 3 && c >= 100 && c < 106) b = (c < 103) ? 8'hF6 : 8'h28;
                if (decoy && r == 3 && c == 50) begin
                    idle(); idle(); idle();
                end
                par ^= b;
                send(b, (mode == 2) || (mode == 1 && (r > 0 || c >= 5)), r, c,
                     (r == 0 && c < 5) ? pre_if : post_if, if_tag,
                     decoy ? "R7 pos" : "R4 pos",
                     b1_on && r == 1 && c == 0, ones(mask));
            end
        end
        prev_par = par;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(in_frame_o == 1'b0 && vld_o == 1'b0, "R1 lock/valid", {in_frame_o, vld_o}, 0);
        chk(sof_o == 1'b0 && b1_vld_o == 1'b0, "R1 flags", {sof_o, b1_vld_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();
        for (int i = 0; i < 40; i++) send(8'(i * 5 + 1), 1'b0, 0, 0, 1'b0, "R2", "R4", 1'b0, 0);
        // first word found, next one missing, then a clean lock
        send_frame(0, 1'b0, 1, 1'b0, 1'b0, 1'b0, 8'h00, "R2", 1'b0);
        send_frame(1, 1'b1, 2, 1'b0, 1'b0, 1'b0, 8'h00, "R3", 1'b0);
        send_frame(2, 1'b0, 2, 1'b0, 1'b0, 1'b0, 8'h00, "R3", 1'b0);
        send_frame(3, 1'b0, 2, 1'b0, 1'b1, 1'b0, 8'h00, "R2", 1'b0);
        send_frame(4, 1'b0, 2, 1'b1, 1'b1, 1'b0, 8'h00, "R9", 1'b0);
        send_frame(5, 1'b0, 2, 1'b1, 1'b1, 1'b1, 8'h00, "R2", 1'b0);
        send_frame(6, 1'b0, 2, 1'b1, 1'b1, 1'b1, 8'h01, "R7", 1'b1);
        send_frame(7, 1'b0, 2, 1'b1, 1'b1, 1'b1, 8'hFF, "R2", 1'b0);
        // three misses then a good word keeps lock
        send_frame(8,  1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h00, "R6", 1'b0);
        send_frame(9,  1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h5A, "R6", 1'b0);
        send_frame(10, 1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h00, "R6", 1'b0);
        send_frame(11, 1'b0, 2, 1'b1, 1'b1, 1'b1, 8'h0F, "R6", 1'b0);
        // four misses lose lock
        send_frame(12, 1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h00, "R6", 1'b0);
        send_frame(13, 1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h00, "R6", 1'b0);
        send_frame(14, 1'b1, 2, 1'b1, 1'b1, 1'b1, 8'h03, "R6", 1'b0);
        send_frame(15, 1'b1, 2, 1'b1, 1'b0, 1'b0, 8'h00, "R6", 1'b0);
        // shift the phase, then lock again at the new position
        for (int i = 0; i < 17; i++) send(8'(i * 3 + 2), 1'b0, 0, 0, 1'b0, "R9", "R4", 1'b0, 0);
        send_frame(16, 1'b0, 1, 1'b0, 1'b0, 1'b0, 8'h00, "R2", 1'b0);
        send_frame(17, 1'b0, 2, 1'b0, 1'b1, 1'b0, 8'h00, "R2", 1'b0);
        send_frame(18, 1'b0, 2, 1'b1, 1'b1, 1'b0, 8'h00, "R9", 1'b0);
        send_frame(19, 1'b0, 2, 1'b1, 1'b1, 1'b1, 8'h80, "R8", 1'b0);
        idle();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule